// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Controller

This block keeps one interrupt flag and one enable mask bit for each message buffer of a CAN-style controller. The transmit and receive engines send a one-cycle pulse when a buffer finishes a transmission or a reception. The pulse sets that buffer's flag. Software reads the flags and the masks over a simple register bus. It clears a flag by writing 1 to its bit, and it rewrites the mask register as a whole. The block combines every flag that is both set and enabled into one interrupt request.

When the receive FIFO is in use, the eight lowest flags change meaning. Bit 7 reports a lost frame, bit 6 reports that the FIFO is almost full, and bit 5 reports that frames are waiting. Bits 4 to 0 are not used. Those FIFO conditions arrive as pulses from the FIFO logic. When abort mode is on, a set flag on a transmit buffer raises a per-buffer write-block output. The buffer storage uses this output to refuse CPU writes into that buffer.

Top module: `mbflag_ctrl`

## Requirements
- R1: After reset, all flag bits and all mask bits are 0, `irq_req` is 0 and every `wr_block` bit is 0.
- R2: Outside FIFO mode, a pulse on `buf_done[i]` sets flag bit i on the next clock edge. In FIFO mode the same holds for every i of 8 or above.
- R3: A bus write to offset 0x30 clears each flag bit whose data bit is 1. Bits written with 0 keep their value. Data bit i (bit 0 is the least significant) maps to buffer i.
- R4: If a set pulse and a write-1 clear hit the same flag bit in one cycle, the bit ends up set.
- R5: A bus write to offset 0x28 loads the whole mask register. A read of 0x28 returns it, and a read of 0x30 returns the flags, in the same bit order as R3. Both reads are combinational.
- R6: `irq_req` is 1 exactly when some bit is set in both the flag register and the mask register. A mask write changes the request in the cycle right after its clock edge.
- R7: In FIFO mode, flag bit 7 is set by `fifo_ovf_pulse`, and `buf_done[7]` has no effect on it.
- R8: In FIFO mode, flag bit 6 is set by `fifo_warn_pulse` and bit 5 by `fifo_avail_pulse`. `buf_done[6]` and `buf_done[5]` have no effect on them. Both bits are cleared by write-1 like the other flags.
- R9: In FIFO mode, `buf_done[4:0]` pulses set no flag.
- R10: Outside FIFO mode, the three FIFO pulses have no effect on any flag.
- R11: `wr_block[i]` is 1 exactly when `abort_mode`, `buf_is_tx[i]` and flag i are all 1. In FIFO mode, `wr_block[7:0]` stays 0.
- R12: A write to any offset other than 0x28 or 0x30 changes no state. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data, bit i for buffer i |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| buf_done | input | 32 | Per-buffer completion pulses |
| fifo_ovf_pulse | input | 1 | FIFO lost-frame pulse |
| fifo_warn_pulse | input | 1 | FIFO almost-full pulse |
| fifo_avail_pulse | input | 1 | FIFO frames-waiting pulse |
| fifo_mode | input | 1 | Turns on the FIFO remapping of the low flags |
| abort_mode | input | 1 | Turns on write blocking for transmit buffers |
| buf_is_tx | input | 32 | Marks each buffer as configured for transmit |
| irq_req | output | 1 | Combined interrupt request |
| wr_block | output | 32 | Per-buffer CPU write block |

## Verification
The bench builds the block with its default parameters: 32 buffers, 8-bit offsets, and the flag and mask registers at 0x30 and 0x28. At this size the whole remapped low byte sits next to ordinary buffers, so one random run reaches set/clear collisions on bits 5 to 7 in both modes. The same run covers FIFO pulses arriving while the mode is off and abort blocking on high and low buffers. It also sets low flags in one mode and then reads and blocks them in the other.

// File: rtl/mbflag_pkg.sv
package mbflag_pkg;
  localparam int FIFO_LO        = 8;
  localparam int FIFO_OVF_BIT   = 7;
  localparam int FIFO_WARN_BIT  = 6;
  localparam int FIFO_AVAIL_BIT = 5;

  localparam logic [7:0] FLAG_OFS_DEF = 8'h30;
  localparam logic [7:0] MASK_OFS_DEF = 8'h28;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/mbflag_setsrc.sv
module mbflag_setsrc
  import mbflag_pkg::*;
#(
  parameter int NUM_BUF = 32
) (
  input  logic [NUM_BUF-1:0] buf_done,
  input  logic               fifo_ovf_pulse,
  input  logic               fifo_warn_pulse,
  input  logic               fifo_avail_pulse,
  input  logic               fifo_mode,
  output logic [NUM_BUF-1:0] set_vec
);
  // Per-bit set sources; the low byte is remapped in FIFO mode.
  function automatic logic [NUM_BUF-1:0] build_set(
    input logic [NUM_BUF-1:0] done,
    input logic ovf, input logic warn, input logic avail,
    input logic fm);
    logic [NUM_BUF-1:0] v;
    v = done;
    if (fm) begin
      v[FIFO_LO-1:0]    = '0;
      v[FIFO_OVF_BIT]   = ovf;
      v[FIFO_WARN_BIT]  = warn;
      v[FIFO_AVAIL_BIT] = avail;
    end
    return v;
  endfunction

  assign set_vec = build_set(buf_done, fifo_ovf_pulse, fifo_warn_pulse,
                             fifo_avail_pulse, fifo_mode);

  // R9: unused low buffers never produce a set in FIFO mode
  always_comb begin
    if (fifo_mode) a_r9_low_silent: assert (set_vec[4:0] == '0);
  end
endmodule

// File: rtl/mbflag_regs.sv
module mbflag_regs
  import mbflag_pkg::*;
#(
  parameter int         NUM_BUF  = 32,
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] FLAG_OFS = FLAG_OFS_DEF,
  parameter logic [7:0] MASK_OFS = MASK_OFS_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_BUF-1:0] bus_wdata,
  input  logic [NUM_BUF-1:0] set_vec,
  output logic [NUM_BUF-1:0] clr_vec,
  output logic [NUM_BUF-1:0] flag_q,
  output logic [NUM_BUF-1:0] mask_q,
  output logic [NUM_BUF-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == FLAG_A)      return SEL_FLAG;
    else if (a == MASK_A) return SEL_MASK;
    else                  return SEL_NONE;
  endfunction

  // Hardware set has priority over the software clear.
  function automatic logic [NUM_BUF-1:0] next_flag(
    input logic [NUM_BUF-1:0] cur, input logic [NUM_BUF-1:0] set,
    input logic [NUM_BUF-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  reg_sel_e sel;
  logic     mask_we;

  assign sel     = decode(bus_addr);
  assign clr_vec = (bus_wr && sel == SEL_FLAG) ? bus_wdata : '0;
  assign mask_we = bus_wr && sel == SEL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= next_flag(flag_q, set_vec, clr_vec);
      if (mask_we) mask_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_FLAG: bus_rdata = flag_q;
      SEL_MASK: bus_rdata = mask_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R2: a set pulse is visible after the edge
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R3: write-1 clears where no set collides
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((flag_q & $past(clr_vec & ~set_vec)) == '0));

  // R3: without set or clear the flags hold
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(flag_q));

  // R5: mask write lands whole
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(bus_wdata)));

  // R12: no write to the mask from other offsets
  a_r12_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/mbflag_out.sv
module mbflag_out
  import mbflag_pkg::*;
#(
  parameter int NUM_BUF = 32
) (
  input  logic [NUM_BUF-1:0] flag_q,
  input  logic [NUM_BUF-1:0] mask_q,
  input  logic               fifo_mode,
  input  logic               abort_mode,
  input  logic [NUM_BUF-1:0] buf_is_tx,
  output logic               irq_req,
  output logic [NUM_BUF-1:0] wr_block
);
  assign irq_req = |(flag_q & mask_q);

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_blk
    if (i < FIFO_LO) begin : g_low
      assign wr_block[i] = abort_mode & buf_is_tx[i] & flag_q[i] & ~fifo_mode;
    end else begin : g_high
      assign wr_block[i] = abort_mode & buf_is_tx[i] & flag_q[i];
    end
  end

  // R11: a block never exists without its flag and abort mode
  always_comb begin
    a_r11_block_needs_flag: assert ((wr_block & ~flag_q) == '0);
    if (!abort_mode) a_r11_block_needs_abort: assert (wr_block == '0);
    if (fifo_mode) a_r11_fifo_low_free: assert (wr_block[FIFO_LO-1:0] == '0);
  end
endmodule

// File: rtl/mbflag_ctrl.sv
module mbflag_ctrl
  import mbflag_pkg::*;
#(
  parameter int         NUM_BUF  = 32,
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] FLAG_OFS = FLAG_OFS_DEF,
  parameter logic [7:0] MASK_OFS = MASK_OFS_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_BUF-1:0] bus_wdata,
  output logic [NUM_BUF-1:0] bus_rdata,
  input  logic [NUM_BUF-1:0] buf_done,
  input  logic               fifo_ovf_pulse,
  input  logic               fifo_warn_pulse,
  input  logic               fifo_avail_pulse,
  input  logic               fifo_mode,
  input  logic               abort_mode,
  input  logic [NUM_BUF-1:0] buf_is_tx,
  output logic               irq_req,
  output logic [NUM_BUF-1:0] wr_block
);
  logic [NUM_BUF-1:0] set_vec;
  logic [NUM_BUF-1:0] clr_vec;
  logic [NUM_BUF-1:0] flag_q;
  logic [NUM_BUF-1:0] mask_q;

  mbflag_setsrc #(.NUM_BUF(NUM_BUF)) u_set (
    .buf_done(buf_done), .fifo_ovf_pulse(fifo_ovf_pulse),
    .fifo_warn_pulse(fifo_warn_pulse), .fifo_avail_pulse(fifo_avail_pulse),
    .fifo_mode(fifo_mode), .set_vec(set_vec));

  mbflag_regs #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W),
                .FLAG_OFS(FLAG_OFS), .MASK_OFS(MASK_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .set_vec(set_vec), .clr_vec(clr_vec),
    .flag_q(flag_q), .mask_q(mask_q), .bus_rdata(bus_rdata));

  mbflag_out #(.NUM_BUF(NUM_BUF)) u_out (
    .flag_q(flag_q), .mask_q(mask_q), .fifo_mode(fifo_mode),
    .abort_mode(abort_mode), .buf_is_tx(buf_is_tx),
    .irq_req(irq_req), .wr_block(wr_block));

  // R4: a collided bit survives its own clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=>
      ((flag_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  // R6: a request always has a flag behind it
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flag_q != '0 && mask_q != '0));

  // R1: the cycle after reset release starts clean
  a_r1_reset_clean: assert property (@(posedge clk)
    $rose(rst_n) |-> (flag_q == '0 && mask_q == '0 && !irq_req));
endmodule

// File: tb/sim_mbflag_ctrl.sv
module sim_mbflag_ctrl;
  localparam int NB = 32;
  localparam logic [7:0] A_FLAG = 8'h30;
  localparam logic [7:0] A_MASK = 8'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [NB-1:0] bus_wdata = '0;
  logic [NB-1:0] bus_rdata;
  logic [NB-1:0] buf_done = '0;
  logic fifo_ovf_pulse = 1'b0, fifo_warn_pulse = 1'b0, fifo_avail_pulse = 1'b0;
  logic fifo_mode = 1'b0, abort_mode = 1'b0;
  logic [NB-1:0] buf_is_tx = '0;
  logic irq_req;
  logic [NB-1:0] wr_block;

  always #10 clk = ~clk;  // 50 MHz

  mbflag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .buf_done(buf_done),
    .fifo_ovf_pulse(fifo_ovf_pulse), .fifo_warn_pulse(fifo_warn_pulse),
    .fifo_avail_pulse(fifo_avail_pulse), .fifo_mode(fifo_mode),
    .abort_mode(abort_mode), .buf_is_tx(buf_is_tx),
    .irq_req(irq_req), .wr_block(wr_block));

  int n_chk = 0;
  int n_bad = 0;
  bit done_all = 0;

  // Reference state, one bit per buffer
  bit m_flag [NB];
  bit m_mask [NB];

  task automatic chk(input string req, input string what,
                     input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit set_src(input int b);
    if (fifo_mode && b < 8) begin
      if (b == 7) return fifo_ovf_pulse;
      if (b == 6) return fifo_warn_pulse;
      if (b == 5) return fifo_avail_pulse;
      return 1'b0;
    end
    return buf_done[b];
  endfunction

  function automatic logic [NB-1:0] pack(input bit v [NB]);
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = v[b];
    return r;
  endfunction

  // Compare the ports against the model (R5, R6, R11, R12)
  task automatic compare_all();
    logic [NB-1:0] exp_rd, exp_blk;
    logic exp_irq;
    exp_irq = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (m_flag[b] && m_mask[b]) exp_irq = 1'b1;
      exp_blk[b] = abort_mode && buf_is_tx[b] && m_flag[b] && !(fifo_mode && b < 8);
    end
    if (bus_addr == A_FLAG) exp_rd = pack(m_flag);
    else if (bus_addr == A_MASK) exp_rd = pack(m_mask);
    else exp_rd = '0;
    chk("R5", "rdata", bus_rdata, exp_rd);
    chk("R6", "irq_req", {{(NB-1){1'b0}}, irq_req}, {{(NB-1){1'b0}}, exp_irq});
    chk("R11", "wr_block", wr_block, exp_blk);
  endtask

  // One clock: model next state from current inputs, then compare
  task automatic tick();
    bit nf [NB];
    bit nm [NB];
    for (int b = 0; b < NB; b++) begin
      bit s, c;
      s = set_src(b);
      c = bus_wr && bus_addr == A_FLAG && bus_wdata[b];
      nf[b] = s ? 1'b1 : (c ? 1'b0 : m_flag[b]);
      nm[b] = (bus_wr && bus_addr == A_MASK) ? bus_wdata[b] : m_mask[b];
    end
    @(posedge clk);
    #1;
    m_flag = nf;
    m_mask = nm;
    compare_all();
  endtask

  task automatic idle();
    bus_wr = 0; buf_done = '0;
    fifo_ovf_pulse = 0; fifo_warn_pulse = 0; fifo_avail_pulse = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [NB-1:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    idle();
  endtask

  task automatic pulse(input logic [NB-1:0] d, input bit ov, input bit wn, input bit av);
    buf_done = d; fifo_ovf_pulse = ov; fifo_warn_pulse = wn; fifo_avail_pulse = av;
    tick();
    idle();
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [NB-1:0] exp);
    bus_addr = a;
    #1;
    chk(req, "read", bus_rdata, exp);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 0);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_flag[b] = 0; m_mask[b] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: clean after reset
    rd("R1", A_FLAG, '0);
    rd("R1", A_MASK, '0);
    chk("R1", "irq/block", {wr_block[NB-1:1], irq_req}, '0);

    // R2: normal-mode set
    pulse(32'h0010_0088, 0, 0, 0);
    rd("R2", A_FLAG, 32'h0010_0088);
    // R3: write-1 clears only written ones
    wr(A_FLAG, 32'h0000_0008);
    rd("R3", A_FLAG, 32'h0010_0080);
    // R4: set wins on collision
    buf_done = 32'h0010_0000;
    wr(A_FLAG, 32'h0010_0000);
    rd("R4", A_FLAG, 32'h0010_0080);
    // R5/R6: mask load and request follows it
    wr(A_MASK, 32'h0010_0000);
    rd("R5", A_MASK, 32'h0010_0000);
    chk("R6", "irq on", {31'd0, irq_req}, 32'd1);
    wr(A_MASK, 32'h0000_0001);
    chk("R6", "irq off", {31'd0, irq_req}, 32'd0);
    // R10: FIFO pulses ignored in normal mode
    wr(A_FLAG, '1);
    pulse('0, 1, 1, 1);
    rd("R10", A_FLAG, '0);
    // R7/R8/R9: FIFO remap
    fifo_mode = 1;
    pulse(32'h0000_00ff, 0, 0, 0);
    rd("R9", A_FLAG, '0);
    pulse('0, 1, 0, 0);
    rd("R7", A_FLAG, 32'h0000_0080);
    pulse('0, 0, 1, 1);
    rd("R8", A_FLAG, 32'h0000_00e0);
    wr(A_FLAG, 32'h0000_0040);
    rd("R8", A_FLAG, 32'h0000_00a0);
    // R11: abort blocking, low byte free in FIFO mode
    abort_mode = 1; buf_is_tx = 32'hffff_ffff;
    pulse(32'h0000_0100, 0, 0, 0);
    #1 chk("R11", "block fifo", wr_block, 32'h0000_0100);
    fifo_mode = 0;
    #1 chk("R11", "block normal", wr_block, 32'h0000_01a0);
    // R12: other offsets
    wr(8'h10, '1);
    rd("R12", 8'h10, '0);
    rd("R12", A_FLAG, 32'h0000_01a0);

    // Random phase against the model every cycle
    for (int k = 0; k < 6000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) fifo_mode = ~fifo_mode;
      if (r >= 3 && r < 6) abort_mode = ~abort_mode;
      if (r >= 6 && r < 8) buf_is_tx = $urandom;
      buf_done = $urandom & $urandom & $urandom;
      fifo_ovf_pulse = ($urandom_range(0, 7) == 0);
      fifo_warn_pulse = ($urandom_range(0, 7) == 0);
      fifo_avail_pulse = ($urandom_range(0, 7) == 0);
      bus_wr = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 4))
        0, 1: bus_addr = A_FLAG;
        2: bus_addr = A_MASK;
        3: bus_addr = 8'h2c;
        default: bus_addr = 8'(int'($urandom_range(0, 255)));
      endcase
      bus_wdata = $urandom;
      tick();
      idle();
    end
    done_all = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule